// File: doc/BRIEF.md
# TDM Timeslot Channel Mapper

This block sits between a PCM frame line and a bank of logical HDLC channels. A frame has 32 timeslots of 8 bits each. The block counts bits and slots from a frame-sync pulse and looks up each slot's assignment word. Receive bits are steered into a packed byte for the slot's receive channel. Transmit bits are drawn from a byte that the channel side supplies for the slot's transmit channel. Each direction has its own inhibit bit, its own 5-bit channel number and its own 8-bit fill mask. The fill mask picks which bit positions of the slot belong to the channel.

The command front end writes the assignment table as 32 consecutive 32-bit words. These start at byte offset 0x0C of the configuration space, so slot `s` lives at `0x0C + 4*s`. The line advances one bit per clock cycle in which `bit_en` is high. The line cannot be stalled, so neither stream has back-pressure. The transmit side must present `tx_byte` in the first bit cycle of every slot. The receiver of `rx_valid` must take each one-cycle strobe as it comes. Strobes are always at least eight bit cycles apart. Rewriting the assignment of a slot while that slot is on the line gives a slot that mixes the old and the new settings.

Top module: `tsm_mapper`

## Requirements
- R1: `slot_num` gives the slot of the current bit. A bit cycle with `fsync` high is bit 0 of slot 0. Every eighth bit cycle starts the next slot, and slot 31 wraps to slot 0 without a sync. Cycles with `bit_en` low leave the position unchanged.
- R2: A write with `cfg_we` high to byte address `0x0C + 4*s` (s in 0..31) replaces the assignment word of slot `s`. Word fields: bit 29 is transmit inhibit, bits 28:24 the transmit channel, bits 23:16 the transmit fill mask, bit 13 receive inhibit, bits 12:8 the receive channel, bits 7:0 the receive fill mask.
- R3: After reset every slot holds word `0x2000_2000`, with both directions inhibited. The line then carries only ones, and no transmit request or receive strobe is given.
- R4: In bit 0 of a slot whose transmit inhibit is clear, `tx_req` is high and `tx_chan` is the transmit channel. `tx_byte` is sampled in that cycle. An inhibited slot gives no `tx_req`.
- R5: Slot bits go out MSB first, so slot bit i is governed by mask bit 7-i. Each position whose transmit mask bit is 1 carries the next bit of `tx_byte`, taken from bit 7 downward. Positions whose mask bit is 0, and every bit of a transmit-inhibited slot, send 1.
- R6: In the cycle after the last bit of a slot whose receive inhibit is clear, `rx_valid` is high for exactly one cycle, and `rx_chan` is the receive channel. A strobe is given even when the mask is zero.
- R7: Received bits at positions whose receive mask bit is 1 are packed into `rx_data` from bit 7 downward. `rx_cnt` is the number of such bits, and the unused low bits of `rx_data` are 0.
- R8: A slot whose receive inhibit is set gives no receive strobe.
- R9: A sync that arrives inside a slot discards the partly received slot, with no strobe. The sync bit then starts slot 0.
- R10: Writes to addresses that are below 0x0C, that are past the last slot word, or that are not word-aligned leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration byte address |
| cfg_word | input | 32 | Configuration write data |
| bit_en | input | 1 | One line bit is present this cycle |
| fsync | input | 1 | Current bit is the first of a frame |
| rx_bit | input | 1 | Received line bit |
| tx_byte | input | 8 | Transmit bits for the slot, MSB first |
| tx_bit | output | 1 | Transmitted line bit |
| tx_req | output | 1 | Transmit byte is taken this cycle |
| tx_chan | output | 5 | Transmit channel of the slot |
| rx_valid | output | 1 | Receive strobe |
| rx_chan | output | 5 | Receive channel of the strobe |
| rx_data | output | 8 | Packed received bits, left-aligned |
| rx_cnt | output | 4 | Number of valid bits in rx_data |
| slot_num | output | 5 | Slot of the current bit |

## Verification
The bound assertions watch properties that hold on every cycle. A sync forces slot 0, and the position holds across idle cycles. Transmit requests and receive strobes appear only with line bits. Strobes never come in consecutive cycles, and packed bytes are always left-aligned with zero unused bits. Whether a given bit went to the right channel under the right mask can only be shown by the bench scenarios. These sweep every 8-bit fill mask value in both directions and mix inhibited and active slots. They also cover frame wrap without a sync, a sync in mid-slot, and writes that fall outside the table window.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int SLOT_BITS = 8;
  localparam int BIT_W     = $clog2(SLOT_BITS);
  localparam int CNT_W     = $clog2(SLOT_BITS + 1);
  localparam int CH_W      = 5;

  // Both directions inhibited: the state of an unconfigured slot.
  localparam logic [31:0] IDLE_WORD = 32'h2000_2000;

  typedef struct packed {
    logic                 inh;
    logic [CH_W-1:0]      chan;
    logic [SLOT_BITS-1:0] mask;
  } dir_cfg_t;

  function automatic dir_cfg_t tx_part(input logic [31:0] w);
    return '{inh: w[29], chan: w[28:24], mask: w[23:16]};
  endfunction

  function automatic dir_cfg_t rx_part(input logic [31:0] w);
    return '{inh: w[13], chan: w[12:8], mask: w[7:0]};
  endfunction
endpackage

// File: rtl/tsm_assign_table.sv
module tsm_assign_table
  import tsm_pkg::*;
#(
  parameter int NSLOT    = 32,
  parameter int ADDR_W   = 10,
  parameter int BASE_OFF = 12,
  localparam int SL_W    = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [SL_W-1:0]   rd_slot,
  output logic [31:0]       rd_word
);
  logic [ADDR_W-1:0] rel;
  logic              hit;
  logic [31:0]       tbl [NSLOT];

  always_comb begin
    rel = addr - ADDR_W'(BASE_OFF);
    hit = we && (addr >= ADDR_W'(BASE_OFF)) && (rel[1:0] == 2'b00) &&
          ({2'b00, rel[ADDR_W-1:2]} < ADDR_W'(NSLOT));
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl[g] <= IDLE_WORD;
      else if (hit && rel[SL_W+1:2] == SL_W'(g))
        tbl[g] <= wdata;
    end
  end

  assign rd_word = tbl[rd_slot];
endmodule

// File: rtl/tsm_slot_counter.sv
module tsm_slot_counter
  import tsm_pkg::*;
#(
  parameter int NSLOT = 32,
  localparam int SL_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  output logic [SL_W-1:0]  cur_slot,
  output logic [BIT_W-1:0] cur_bit,
  output logic             first_bit,
  output logic             last_bit
);
  logic [SL_W-1:0]  slot_q;
  logic [BIT_W-1:0] bit_q;
  logic             restart;

  always_comb begin
    restart   = bit_en && fsync;
    cur_slot  = restart ? '0 : slot_q;
    cur_bit   = restart ? '0 : bit_q;
    first_bit = (cur_bit == '0);
    last_bit  = (cur_bit == BIT_W'(SLOT_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      bit_q  <= '0;
    end else if (bit_en) begin
      if (last_bit) begin
        bit_q  <= '0;
        slot_q <= (cur_slot == SL_W'(NSLOT - 1)) ? '0 : cur_slot + 1'b1;
      end else begin
        bit_q  <= cur_bit + 1'b1;
        slot_q <= cur_slot;
      end
    end
  end
endmodule

// File: rtl/tsm_tx_unpack.sv
module tsm_tx_unpack
  import tsm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 first_bit,
  input  logic [BIT_W-1:0]     cur_bit,
  input  dir_cfg_t             cfg,
  input  logic [SLOT_BITS-1:0] tx_byte,
  output logic                 tx_bit,
  output logic                 tx_req
);
  logic [SLOT_BITS-1:0] sh_q, base;
  logic [BIT_W-1:0]     pos;
  logic                 carry;

  always_comb begin
    base   = first_bit ? tx_byte : sh_q;
    pos    = BIT_W'(SLOT_BITS - 1) - cur_bit;
    carry  = !cfg.inh && cfg.mask[pos];
    tx_bit = carry ? base[SLOT_BITS-1] : 1'b1;
    tx_req = bit_en && first_bit && !cfg.inh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sh_q <= '0;
    else if (bit_en)
      sh_q <= carry ? {base[SLOT_BITS-2:0], 1'b0} : base;
  end
endmodule

// File: rtl/tsm_rx_pack.sv
module tsm_rx_pack
  import tsm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 first_bit,
  input  logic                 last_bit,
  input  logic [BIT_W-1:0]     cur_bit,
  input  dir_cfg_t             cfg,
  input  logic                 rx_bit,
  output logic                 rx_valid,
  output logic [CH_W-1:0]      rx_chan,
  output logic [SLOT_BITS-1:0] rx_data,
  output logic [CNT_W-1:0]     rx_cnt
);
  logic [SLOT_BITS-1:0] sh_q, base_sh, sh_nxt;
  logic [CNT_W-1:0]     n_q, base_n, n_nxt;
  logic [BIT_W-1:0]     pos;
  logic                 keep;

  always_comb begin
    base_sh = first_bit ? '0 : sh_q;
    base_n  = first_bit ? '0 : n_q;
    pos     = BIT_W'(SLOT_BITS - 1) - cur_bit;
    keep    = cfg.mask[pos];
    sh_nxt  = base_sh;
    if (keep)
      sh_nxt = base_sh | (SLOT_BITS'(rx_bit) << (BIT_W'(SLOT_BITS - 1) - base_n[BIT_W-1:0]));
    n_nxt   = base_n + CNT_W'(keep);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q     <= '0;
      n_q      <= '0;
      rx_valid <= 1'b0;
      rx_chan  <= '0;
      rx_data  <= '0;
      rx_cnt   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (bit_en) begin
        sh_q <= sh_nxt;
        n_q  <= n_nxt;
        if (last_bit && !cfg.inh) begin
          rx_valid <= 1'b1;
          rx_chan  <= cfg.chan;
          rx_data  <= sh_nxt;
          rx_cnt   <= n_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/tsm_mapper.sv
module tsm_mapper
  import tsm_pkg::*;
#(
  parameter int NSLOT    = 32,
  parameter int ADDR_W   = 10,
  parameter int BASE_OFF = 12,
  localparam int SL_W    = $clog2(NSLOT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_word,
  input  logic                 bit_en,
  input  logic                 fsync,
  input  logic                 rx_bit,
  input  logic [SLOT_BITS-1:0] tx_byte,
  output logic                 tx_bit,
  output logic                 tx_req,
  output logic [CH_W-1:0]      tx_chan,
  output logic                 rx_valid,
  output logic [CH_W-1:0]      rx_chan,
  output logic [SLOT_BITS-1:0] rx_data,
  output logic [CNT_W-1:0]     rx_cnt,
  output logic [SL_W-1:0]      slot_num
);
  logic [SL_W-1:0]  cur_slot;
  logic [BIT_W-1:0] cur_bit;
  logic             first_bit, last_bit;
  logic [31:0]      word;
  dir_cfg_t         tx_cfg, rx_cfg;

  tsm_slot_counter #(.NSLOT(NSLOT)) u_cnt (
    .clk, .rst_n, .bit_en, .fsync,
    .cur_slot, .cur_bit, .first_bit, .last_bit
  );

  tsm_assign_table #(.NSLOT(NSLOT), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_tbl (
    .clk, .rst_n, .we(cfg_we), .addr(cfg_addr), .wdata(cfg_word),
    .rd_slot(cur_slot), .rd_word(word)
  );

  assign tx_cfg   = tx_part(word);
  assign rx_cfg   = rx_part(word);
  assign tx_chan  = tx_cfg.chan;
  assign slot_num = cur_slot;

  tsm_tx_unpack u_tx (
    .clk, .rst_n, .bit_en, .first_bit, .cur_bit,
    .cfg(tx_cfg), .tx_byte, .tx_bit, .tx_req
  );

  tsm_rx_pack u_rx (
    .clk, .rst_n, .bit_en, .first_bit, .last_bit, .cur_bit,
    .cfg(rx_cfg), .rx_bit, .rx_valid, .rx_chan, .rx_data, .rx_cnt
  );
endmodule

// File: rtl/tsm_mapper_chk.sv
module tsm_mapper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       fsync,
  input logic       tx_req,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic [3:0] rx_cnt,
  input logic [4:0] slot_num
);
  // R1
  sync_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |-> (slot_num == 5'd0));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !$past(bit_en)) |-> $stable(slot_num));

  // R4
  tx_req_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> bit_en);

  // R6
  strobe_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_en));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  pack_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_cnt <= 4'd8 && (rx_data & (8'hFF >> rx_cnt)) == 8'h00));
endmodule

bind tsm_mapper tsm_mapper_chk u_chk (.*);

// File: tb/tsm_mapper_tb.sv
module tsm_mapper_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_addr = '0;
  logic [31:0] cfg_word = '0;
  logic       bit_en = 1'b0;
  logic       fsync = 1'b0;
  logic       rx_bit = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       tx_bit, tx_req, rx_valid;
  logic [4:0] tx_chan, rx_chan, slot_num;
  logic [7:0] rx_data;
  logic [3:0] rx_cnt;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit idle_tbl = 1;
  int cur_f = 0;
  int mslot = 0, mbit = 0, txn = 0, rxn = 0;
  logic [7:0] rx_acc;

  always #10 clk = ~clk;

  tsm_mapper u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_word, .bit_en, .fsync, .rx_bit,
    .tx_byte, .tx_bit, .tx_req, .tx_chan, .rx_valid, .rx_chan, .rx_data,
    .rx_cnt, .slot_num
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (frame %0d slot %0d bit %0d)",
               req, act, exp, cur_f, mslot, mbit);
    end
  endtask

  function automatic logic [31:0] word_of(input int f, input int s);
    logic tti, rti;
    logic [4:0] tcn, rcn;
    logic [7:0] tfm, rfm;
    if (idle_tbl) return 32'h2000_2000;
    tti = (s % 7 == 3);
    rti = (s % 5 == 2);
    tcn = 5'((s * 7 + f + 3) % 32);
    rcn = 5'((s * 13 + f * 3 + 1) % 32);
    tfm = 8'((f * 32 + s) % 256);
    rfm = 8'(((f * 32 + s) * 37) % 256);
    return {2'b00, tti, tcn, tfm, 2'b00, rti, rcn, rfm};
  endfunction

  function automatic logic [7:0] txb_of(input int f, input int s);
    return 8'((f * 29 + s * 53 + 17) % 256);
  endfunction

  function automatic logic rxb_of(input int f, input int s, input int i);
    return 1'(((f * 3 + s * 5 + i * 7 + ((s * i) >> 2)) >> 1) & 1);
  endfunction

  task automatic load_table();
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      bit_en = 0; fsync = 0;
      cfg_we = 1; cfg_addr = 10'(12 + 4 * s); cfg_word = word_of(cur_f, s);
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  // R10: writes outside the window or misaligned must not land in the table
  task automatic stray_writes();
    int addrs [3] = '{8, 12 + 4 * 32, 13};
    foreach (addrs[k]) begin
      @(negedge clk);
      cfg_we = 1; cfg_addr = 10'(addrs[k]); cfg_word = 32'h1F00_1F00;
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run_bit(input logic fs);
    logic [31:0] w;
    logic [7:0] tb;
    logic rb, carry, eb;
    if (fs) begin mslot = 0; mbit = 0; end
    w = word_of(cur_f, mslot);
    if (mbit == 0) begin txn = 0; rxn = 0; rx_acc = '0; end
    tb = txb_of(cur_f, mslot);
    rb = rxb_of(cur_f, mslot, mbit);
    @(negedge clk);
    bit_en = 1; fsync = fs; rx_bit = rb; tx_byte = tb;
    #1;
    chk(slot_num == 5'(mslot), "R1 slot position", slot_num, mslot);
    carry = !w[29] && w[16 + 7 - mbit];
    eb = carry ? tb[7 - txn] : 1'b1;
    if (carry) txn++;
    chk(tx_bit == eb, w[29] ? "R5 inhibited tx bit" : "R5 tx bit", tx_bit, eb);
    if (mbit == 0) begin
      chk(tx_req == !w[29], "R4 tx_req", tx_req, !w[29]);
      if (!w[29]) chk(tx_chan == w[28:24], "R4 tx_chan", tx_chan, w[28:24]);
    end else begin
      chk(tx_req == 1'b0, "R4 tx_req mid-slot", tx_req, 0);
    end
    if (w[7 - mbit]) begin rx_acc[7 - rxn] = rb; rxn++; end
    @(posedge clk);
    #1;
    if (mbit == 7 && !w[13]) begin
      chk(rx_valid == 1'b1, "R6 rx strobe", rx_valid, 1);
      chk(rx_chan == w[12:8], "R6 rx_chan", rx_chan, w[12:8]);
      chk(rx_data == rx_acc, "R7 rx_data", rx_data, rx_acc);
      chk(rx_cnt == 4'(rxn), "R7 rx_cnt", rx_cnt, rxn);
    end else begin
      chk(rx_valid == 1'b0, (mbit == 7) ? "R8 inhibited rx" : "R6 no strobe", rx_valid, 0);
    end
    mbit++;
    if (mbit == 8) begin mbit = 0; mslot = (mslot + 1) % 32; end
    if ((mslot * 3 + mbit) % 11 == 0) begin
      @(negedge clk);
      bit_en = 0; fsync = 0;
      #1;
      chk(slot_num == 5'(mslot), "R1 hold while idle", slot_num, mslot);
      @(posedge clk);
      #1;
      chk(rx_valid == 1'b0, "R6 no strobe while idle", rx_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R3: reset table inhibits everything
    chk(rx_valid == 1'b0, "R3 reset rx_valid", rx_valid, 0);
    for (int i = 0; i < 16; i++) run_bit(i == 0);
    idle_tbl = 0;
    for (int f = 0; f < 8; f++) begin
      cur_f = f;
      load_table();                         // R2
      if (f == 2) stray_writes();           // R10
      for (int i = 0; i < 256; i++) run_bit(i == 0 && f % 2 == 0);
    end
    // R9: sync arrives in slot 3 bit 4
    cur_f = 8;
    load_table();
    for (int i = 0; i < 28; i++) run_bit(1'b0);
    for (int i = 0; i < 256; i++) run_bit(i == 0);
    @(negedge clk);
    bit_en = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule